// File: doc/BRIEF.md
# Strobe-Started Serial-to-Parallel Receiver

This block gathers a word that arrives one bit per clock on a single serial line and presents it as a parallel word. A one-cycle strobe marks the start of a word. The first bit, which is the most significant one, is present on the serial line in that same cycle. The receiver takes it at that edge, so no cycle is lost between the strobe and the data.

The receiver then takes one further bit on each following clock until the whole word is in. A bit counter and a shift register hold the word while it is being built. The finished word is copied to the output register in one step, so a half-built word is never visible on the output.

A `done` flag is high whenever the receiver can accept a new word. A sender can raise the next strobe in the very first cycle that `done` is high again, which allows words to follow each other with no gap.

Top module: `strobe_deser`

## Requirements
- R1: After reset, `wordOut` is all zeros and `done` is 1.
- R2: When `dataValid` is 1 in a cycle where `done` is 1, the `serIn` value of that same cycle is taken as the first bit of a word, and `done` is 0 from the next cycle on.
- R3: Bits arrive most significant first. The bit on `serIn` in cycle c+i, where c is the strobe cycle, lands in `wordOut[WORD_W-1-i]`.
- R4: At the edge that ends cycle c+WORD_W-1, `wordOut` takes the complete word and `done` returns to 1. `done` stays 0 for every cycle in between.
- R5: `wordOut` changes only when a word completes. A partly received word never appears on it.
- R6: A `dataValid` pulse while `done` is 0 is ignored. The word in progress, its bit order and its completion cycle are unchanged.
- R7: A strobe in the first cycle that `done` is high again, right after a word completes, starts a new word at once.
- R8: While no word is in progress and `dataValid` is 0, `serIn` has no effect on `wordOut` or `done`.
- R9: `WORD_W` must be at least 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Serial data bit, most significant first |
| dataValid | input | 1 | One-cycle start strobe, aligned with the first bit |
| wordOut | output | WORD_W | Last completed word |
| done | output | 1 | High when the receiver is free for a new word |

## Verification
The bench builds two instances: one with the default `WORD_W` of 8 and one with `WORD_W` of 2. The 8-bit instance covers the full bit order and the places a stray mid-word strobe can fall. The 2-bit instance covers the shortest legal word, where the strobe cycle and the completion cycle are only one clock apart and the counter's first and last values meet. Both instances receive back-to-back words with the next strobe in the first free cycle, and idle gaps in which the serial line toggles.

// File: rtl/strobe_deser_pkg.sv
package strobe_deser_pkg;
  // Strobes sent from the control to the datapath, one set per cycle.
  typedef struct packed {
    logic loadFirst; // take the first bit of a new word
    logic shiftBit;  // append the current bit to the word being built
    logic commit;    // the current bit is the last one; publish the word
  } deserCtl_t;
endpackage

// File: rtl/strobe_deser_ctrl.sv
module strobe_deser_ctrl
  import strobe_deser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dataValid,
  output deserCtl_t ctl,
  output logic      done
);
  localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  typedef enum logic {ST_IDLE, ST_RECV} state_t;

  state_t           state;
  logic [CNT_W-1:0] bitCnt; // number of bits already stored

  always_comb begin
    ctl.loadFirst = (state == ST_IDLE) && dataValid;
    ctl.shiftBit  = (state == ST_RECV);
    ctl.commit    = (state == ST_RECV) && (bitCnt == LAST_IDX);
    done          = (state == ST_IDLE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      bitCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (dataValid) begin
          state  <= ST_RECV;
          bitCnt <= CNT_W'(1);
        end
        ST_RECV: if (bitCnt == LAST_IDX) begin
          state  <= ST_IDLE;
          bitCnt <= '0;
        end else begin
          bitCnt <= bitCnt + CNT_W'(1);
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && dataValid) |=> !done);
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !ctl.commit) |=> !done);
  // R4
  finish_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (done && !$past(ctl.loadFirst)));
  // R8
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && !dataValid) |=> done);
  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= LAST_IDX);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ctl.loadFirst, ctl.shiftBit}));
endmodule

// File: rtl/strobe_deser_path.sv
module strobe_deser_path
  import strobe_deser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  deserCtl_t         ctl,
  output logic [WORD_W-1:0] wordOut
);
  logic [WORD_W-1:0] shiftReg;
  logic [WORD_W-1:0] nextWord;

  assign nextWord = {shiftReg[WORD_W-2:0], serIn};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (ctl.loadFirst) begin
      shiftReg <= {{(WORD_W-1){1'b0}}, serIn};
    end else if (ctl.shiftBit) begin
      shiftReg <= nextWord;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wordOut <= '0;
    end else if (ctl.commit) begin
      wordOut <= nextWord;
    end
  end

  // R5
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.commit |=> $stable(wordOut));
  // R3
  commit_lsb_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.commit |=> (wordOut[0] == $past(serIn)));
endmodule

// File: rtl/strobe_deser.sv
module strobe_deser
  import strobe_deser_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  logic              dataValid,
  output logic [WORD_W-1:0] wordOut,
  output logic              done
);
  // R9
  initial width_chk: assert (WORD_W >= 2);

  deserCtl_t ctl;

  strobe_deser_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .dataValid(dataValid), .ctl(ctl), .done(done)
  );

  strobe_deser_path #(.WORD_W(WORD_W)) u_path (
    .clk(clk), .rstN(rstN), .serIn(serIn), .ctl(ctl), .wordOut(wordOut)
  );
endmodule

// File: tb/strobe_deser_tb.sv
module strobe_deser_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIDE_W = 8;
  localparam int NARROW_W = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic xWide = 1'b0, dvWide = 1'b0, xNar = 1'b0, dvNar = 1'b0;
  logic [WIDE_W-1:0] wordWide;
  logic [NARROW_W-1:0] wordNar;
  logic doneWide, doneNar;

  int errCnt = 0;
  int chkCnt = 0;
  bit finished = 1'b0;
  logic [WIDE_W-1:0] lastWide = '0;
  logic [WIDE_W-1:0] lastNar = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strobe_deser #(.WORD_W(WIDE_W)) u_dut (
    .clk(clk), .rstN(rstN), .serIn(xWide), .dataValid(dvWide),
    .wordOut(wordWide), .done(doneWide)
  );

  strobe_deser #(.WORD_W(NARROW_W)) u_dut2 (
    .clk(clk), .rstN(rstN), .serIn(xNar), .dataValid(dvNar),
    .wordOut(wordNar), .done(doneNar)
  );

  task automatic check(input bit ok, input string req, input logic [WIDE_W-1:0] act,
                       input logic [WIDE_W-1:0] exp);
    chkCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [WIDE_W-1:0] getWord(input bit nar);
    return nar ? WIDE_W'(wordNar) : wordWide;
  endfunction

  function automatic logic getDone(input bit nar);
    return nar ? doneNar : doneWide;
  endfunction

  task automatic drive(input bit nar, input logic x, input logic dv);
    if (nar) begin xNar = x; dvNar = dv; end
    else     begin xWide = x; dvWide = dv; end
  endtask

  // Send one word starting at the current negedge. dvMid > 0 adds a
  // stray strobe in that bit cycle (R6).
  task automatic sendWord(input bit nar, input logic [WIDE_W-1:0] w, input int dvMid);
    int n = nar ? NARROW_W : WIDE_W;
    logic [WIDE_W-1:0] prev = nar ? lastNar : lastWide;
    logic [WIDE_W-1:0] expW = w & ((WIDE_W'(1) << n) - 1'b1);
    if (nar && n == WIDE_W) expW = w;
    for (int i = 0; i < n; i++) begin
      drive(nar, w[n-1-i], (i == 0) || (i == dvMid && dvMid > 0));
      @(negedge clk);
      if (i < n-1) begin
        check(getDone(nar) == 1'b0, "R2/R6 done low mid-word", WIDE_W'(getDone(nar)), '0);
        check(getWord(nar) == prev, "R5 no partial word", getWord(nar), prev);
      end else begin
        check(getDone(nar) == 1'b1, "R4 done after last bit", WIDE_W'(getDone(nar)), 1);
        check(getWord(nar) == expW, "R3 word MSB first", getWord(nar), expW);
      end
    end
    drive(nar, 1'b0, 1'b0);
    if (nar) lastNar = expW; else lastWide = expW;
  endtask

  // Idle cycles with the serial line toggling and no strobe (R8).
  task automatic idleNoise(input bit nar, input int cycles);
    for (int i = 0; i < cycles; i++) begin
      drive(nar, i[0] ^ 1'b1, 1'b0);
      @(negedge clk);
      check(getDone(nar) == 1'b1, "R8 done stays high idle", WIDE_W'(getDone(nar)), 1);
      check(getWord(nar) == (nar ? lastNar : lastWide), "R8 idle serial ignored",
            getWord(nar), nar ? lastNar : lastWide);
    end
    drive(nar, 1'b0, 1'b0);
  endtask

  task automatic testReset();
    check(wordWide == '0, "R1 reset word", wordWide, '0);
    check(doneWide == 1'b1, "R1 reset done", WIDE_W'(doneWide), 1);
    check(wordNar == '0, "R1 reset word narrow", WIDE_W'(wordNar), '0);
    check(doneNar == 1'b1, "R1 reset done narrow", WIDE_W'(doneNar), 1);
  endtask

  task automatic testBackToBack(input bit nar);
    // R7: each new strobe lands in the first cycle done is high again
    sendWord(nar, 8'hA5, 0);
    sendWord(nar, 8'h3C, 0);
    sendWord(nar, 8'hFF, 0);
    sendWord(nar, 8'h01, 0);
  endtask

  task automatic testStrayStrobe();
    // R6: stray strobes at several positions inside a word
    sendWord(1'b0, 8'h96, 1);
    sendWord(1'b0, 8'h4B, 4);
    sendWord(1'b0, 8'hC3, WIDE_W-1);
  endtask

  task automatic testRandom(input bit nar, input int count);
    for (int k = 0; k < count; k++) begin
      logic [WIDE_W-1:0] w = WIDE_W'($urandom);
      sendWord(nar, w, 0);
      if (k[1:0] == 2'd3) idleNoise(nar, 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      finished = 1'b1;
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    idleNoise(1'b0, 4);
    idleNoise(1'b1, 4);
    testBackToBack(1'b0);
    testBackToBack(1'b1);
    testStrayStrobe();
    idleNoise(1'b0, 3);
    testRandom(1'b0, 20);
    testRandom(1'b1, 20);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule